// File: doc/BRIEF.md
# Registered Cascadable Magnitude Comparator

This block compares two stored operand words, A and B, and presents three decoded verdicts: A above B, A below B, and A equal to B. A mode pin selects whether the words are read as plain unsigned binary or as two's-complement signed numbers. Each operand has its own load enable, and the three verdicts pass through a result register with a load enable of its own. The result can therefore be frozen while new operands are staged, or the operands can be held while the result tracks changing cascade inputs.

A synchronous clear forces the stored B word to zero, so A is tested against zero without loading a zero through the data pins. Two cascade inputs carry the above/below verdict of a less significant stage. When the local words are equal, the verdict comes from those inputs. Wide words are built by chaining stages: each stage's above and below outputs drive the cascade inputs of the next more significant stage, and the equal outputs of all stages are ANDed. Only the top stage runs in signed mode. All lower stages are unsigned.

Top module: `lmc_top`

## Requirements
- R1: With `unsigned_mode` high, the operands are compared as unsigned binary values, so 0x80 is above 0x7F and 0xFF is above 0x00.
- R2: With `unsigned_mode` low, the operands are compared as two's-complement values, so 0x80 is below 0x7F and 0xFF is below 0x00.
- R3: When the stored words differ, the above/below verdict depends only on the words, and the cascade inputs have no effect. `eq_out` is low and exactly one of `gt_out` and `lt_out` is high.
- R4: When the stored words are equal and both cascade inputs are low, `eq_out` is high and `gt_out` and `lt_out` are low.
- R5: When the stored words are equal and exactly one cascade input is high, the output of the same name is high and the other two outputs are low.
- R6: When the stored words are equal and both cascade inputs are high, `gt_out` and `lt_out` are both high and `eq_out` is low.
- R7: Each of the A, B and result registers loads on a rising clock edge while its enable is high and holds otherwise. With all enables high, a new operand pair appears at the outputs after the second rising edge.
- R8: A rising edge with `b_clr_n` low sets the stored B word to zero, whatever `b_ld` does. A stays untouched.
- R9: `rst_n` low asynchronously sets the stored A, B and result to zero, so all three outputs read low.
- R10: In a two-stage chain, the low stage is unsigned with its cascade inputs tied low, and the high stage's cascade inputs are driven from the low stage. The high stage's above/below outputs and the AND of both equal outputs then give the correct comparison of the 16-bit words, in either mode of the high stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unsigned_mode | input | 1 | 1 = unsigned compare, 0 = two's-complement compare |
| a_in | input | W | Operand A data |
| b_in | input | W | Operand B data |
| a_ld | input | 1 | Load enable for stored A |
| b_ld | input | 1 | Load enable for stored B |
| b_clr_n | input | 1 | Active-low clear of stored B (priority over b_ld) |
| res_ld | input | 1 | Load enable for the result register |
| casc_gt_in | input | 1 | Above verdict from the less significant stage |
| casc_lt_in | input | 1 | Below verdict from the less significant stage |
| gt_out | output | 1 | A above B |
| lt_out | output | 1 | A below B |
| eq_out | output | 1 | A equal to B with no cascade verdict |

## Verification
The hardest condition to reach is a verdict in one register that disagrees with the operands in the other registers. This happens, for example, when a new operand has been loaded while the result register is frozen. It also happens when B has been cleared and is then held with its load enable low. Directed sequences build these states by dropping single enables between edges and checking that the outputs keep the old verdict until the result register is loaded again. The two-stage chain needs three edges before its final verdict settles, so its checks sample only after that point.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
  } verdict_t;
endpackage

// File: rtl/lmc_word_reg.sv
module lmc_word_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic         clr_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_nxt;

  // clear outranks load
  always_comb begin
    q_nxt = q_r;
    if (!clr_n)  q_nxt = '0;
    else if (ld) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;

  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (q == '0));

  a_r7_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !ld) |=> $stable(q));
endmodule

// File: rtl/lmc_core.sv
module lmc_core
  import lmc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         unsigned_mode,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         casc_gt,
  input  logic         casc_lt,
  output verdict_t     v
);
  localparam int MSB = W - 1;

  logic [W-1:0] a_k, b_k;

  // signed order equals unsigned order once the sign bits are inverted
  always_comb begin
    a_k = a;
    b_k = b;
    if (!unsigned_mode) begin
      a_k[MSB] = ~a[MSB];
      b_k[MSB] = ~b[MSB];
    end
  end

  always_comb begin
    if (a_k > b_k) begin
      v = '{gt: 1'b1, lt: 1'b0, eq: 1'b0};
    end else if (a_k < b_k) begin
      v = '{gt: 1'b0, lt: 1'b1, eq: 1'b0};
    end else begin
      v = '{gt: casc_gt, lt: casc_lt, eq: !casc_gt && !casc_lt};
    end
  end
endmodule

// File: rtl/lmc_res_reg.sv
module lmc_res_reg
  import lmc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ld,
  input  verdict_t d,
  output verdict_t q
);
  verdict_t q_r, q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (ld) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;

  a_r7_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(q));
endmodule

// File: rtl/lmc_top.sv
module lmc_top
  import lmc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         unsigned_mode,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         a_ld,
  input  logic         b_ld,
  input  logic         b_clr_n,
  input  logic         res_ld,
  input  logic         casc_gt_in,
  input  logic         casc_lt_in,
  output logic         gt_out,
  output logic         lt_out,
  output logic         eq_out
);
  logic [W-1:0] a_q, b_q;
  verdict_t     v_comb, v_q;

  lmc_word_reg #(.W(W)) u_a_reg (
    .clk(clk), .rst_n(rst_n), .ld(a_ld), .clr_n(1'b1), .d(a_in), .q(a_q)
  );

  lmc_word_reg #(.W(W)) u_b_reg (
    .clk(clk), .rst_n(rst_n), .ld(b_ld), .clr_n(b_clr_n), .d(b_in), .q(b_q)
  );

  lmc_core #(.W(W)) u_core (
    .unsigned_mode(unsigned_mode), .a(a_q), .b(b_q),
    .casc_gt(casc_gt_in), .casc_lt(casc_lt_in), .v(v_comb)
  );

  lmc_res_reg u_res (
    .clk(clk), .rst_n(rst_n), .ld(res_ld), .d(v_comb), .q(v_q)
  );

  assign gt_out = v_q.gt;
  assign lt_out = v_q.lt;
  assign eq_out = v_q.eq;

  a_r3_differ_decides: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ld && (a_q != b_q)) |=> (!eq_out && (gt_out != lt_out)));

  a_r4_eq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    eq_out |-> (!gt_out && !lt_out));

  a_r6_both_cascade: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ld && (a_q == b_q) && casc_gt_in && casc_lt_in) |=> (gt_out && lt_out && !eq_out));
endmodule

// File: tb/sim_lmc_top.sv
module sim_lmc_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic unsigned_mode = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic a_ld = 1'b0, b_ld = 1'b0, b_clr_n = 1'b1, res_ld = 1'b0;
  logic casc_gt_in = 1'b0, casc_lt_in = 1'b0;
  logic gt_out, lt_out, eq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lmc_top #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .unsigned_mode(unsigned_mode),
    .a_in(a_in), .b_in(b_in), .a_ld(a_ld), .b_ld(b_ld), .b_clr_n(b_clr_n),
    .res_ld(res_ld), .casc_gt_in(casc_gt_in), .casc_lt_in(casc_lt_in),
    .gt_out(gt_out), .lt_out(lt_out), .eq_out(eq_out)
  );

  // two-stage 16-bit chain
  logic       ch_mode = 1'b1;
  logic [7:0] ch_alo = '0, ch_blo = '0, ch_ahi = '0, ch_bhi = '0;
  logic       lo_gt, lo_lt, lo_eq, hi_gt, hi_lt, hi_eq;

  lmc_top #(.W(8)) u1 (
    .clk(clk), .rst_n(rst_n), .unsigned_mode(1'b1),
    .a_in(ch_alo), .b_in(ch_blo), .a_ld(1'b1), .b_ld(1'b1), .b_clr_n(1'b1),
    .res_ld(1'b1), .casc_gt_in(1'b0), .casc_lt_in(1'b0),
    .gt_out(lo_gt), .lt_out(lo_lt), .eq_out(lo_eq)
  );

  lmc_top #(.W(8)) u2 (
    .clk(clk), .rst_n(rst_n), .unsigned_mode(ch_mode),
    .a_in(ch_ahi), .b_in(ch_bhi), .a_ld(1'b1), .b_ld(1'b1), .b_clr_n(1'b1),
    .res_ld(1'b1), .casc_gt_in(lo_gt), .casc_lt_in(lo_lt),
    .gt_out(hi_gt), .lt_out(hi_lt), .eq_out(hi_eq)
  );

  // vector: [21] mode, [20] casc_gt, [19] casc_lt, [18:11] A, [10:3] B, [2:0] expected {gt,lt,eq}
  localparam int NV = 19;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 8'h05, 8'h05, 3'b001},
    {1'b1, 1'b0, 1'b1, 8'h05, 8'h05, 3'b010},
    {1'b1, 1'b1, 1'b0, 8'h05, 8'h05, 3'b100},
    {1'b1, 1'b1, 1'b1, 8'h05, 8'h05, 3'b110},
    {1'b1, 1'b0, 1'b0, 8'h09, 8'h05, 3'b100},
    {1'b1, 1'b0, 1'b1, 8'h09, 8'h05, 3'b100},
    {1'b1, 1'b1, 1'b0, 8'h03, 8'h05, 3'b010},
    {1'b1, 1'b1, 1'b1, 8'h03, 8'h05, 3'b010},
    {1'b0, 1'b0, 1'b0, 8'h80, 8'h80, 3'b001},
    {1'b0, 1'b0, 1'b1, 8'h80, 8'h80, 3'b010},
    {1'b0, 1'b1, 1'b0, 8'h80, 8'h80, 3'b100},
    {1'b0, 1'b1, 1'b1, 8'h80, 8'h80, 3'b110},
    {1'b0, 1'b0, 1'b0, 8'h80, 8'h7F, 3'b010},
    {1'b0, 1'b1, 1'b1, 8'hFF, 8'h00, 3'b010},
    {1'b0, 1'b0, 1'b1, 8'h7F, 8'h80, 3'b100},
    {1'b0, 1'b1, 1'b0, 8'h00, 8'hFF, 3'b100},
    {1'b1, 1'b0, 1'b0, 8'h80, 8'h7F, 3'b100},
    {1'b1, 1'b0, 1'b0, 8'hFF, 8'h00, 3'b100},
    {1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, 3'b010}
  };

  function automatic string req_of(logic [21:0] v);
    if (v[18:11] != v[10:3]) return v[21] ? "R1/R3" : "R2/R3";
    if (v[20] && v[19])      return "R6";
    if (v[20] || v[19])      return "R5";
    return "R4";
  endfunction

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got gt/lt/eq=%b expected %b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // all enables high, two edges, sample on the falling edge
  task automatic apply(logic m, logic cg, logic cl, logic [7:0] a, logic [7:0] b);
    @(negedge clk);
    unsigned_mode = m; casc_gt_in = cg; casc_lt_in = cl;
    a_in = a; b_in = b; a_ld = 1'b1; b_ld = 1'b1; res_ld = 1'b1; b_clr_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic chain(logic m, logic [15:0] a, logic [15:0] b);
    logic [2:0] exp;
    logic       g, l;
    @(negedge clk);
    ch_mode = m;
    ch_alo = a[7:0]; ch_blo = b[7:0]; ch_ahi = a[15:8]; ch_bhi = b[15:8];
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    g = m ? (a > b) : ($signed(a) > $signed(b));
    l = m ? (a < b) : ($signed(a) < $signed(b));
    exp = {g, l, (a == b)};
    check("R10", {hi_gt, hi_lt, hi_eq & lo_eq}, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] xa, xb;
    repeat (2) @(negedge clk);
    check("R9 reset", {gt_out, lt_out, eq_out}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after release", {gt_out, lt_out, eq_out}, 3'b000);

    // table walk: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][21], VEC[i][20], VEC[i][19], VEC[i][18:11], VEC[i][10:3]);
      check(req_of(VEC[i]), {gt_out, lt_out, eq_out}, VEC[i][2:0]);
    end

    // R7: operand hold
    apply(1'b1, 1'b0, 1'b0, 8'h10, 8'h20);
    check("R7 load", {gt_out, lt_out, eq_out}, 3'b010);
    @(negedge clk); a_in = 8'h30; a_ld = 1'b0; b_ld = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R7 a hold", {gt_out, lt_out, eq_out}, 3'b010);
    // R7: result hold while A updates
    res_ld = 1'b0; a_ld = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R7 res hold", {gt_out, lt_out, eq_out}, 3'b010);
    res_ld = 1'b1; a_ld = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R7 res load", {gt_out, lt_out, eq_out}, 3'b100);

    // R8: clear outranks load
    apply(1'b1, 1'b0, 1'b0, 8'h05, 8'h05);
    check("R8 pre", {gt_out, lt_out, eq_out}, 3'b001);
    @(negedge clk); b_in = 8'h20; b_ld = 1'b1; b_clr_n = 1'b0; a_ld = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R8 clear", {gt_out, lt_out, eq_out}, 3'b100);
    b_clr_n = 1'b1; b_ld = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R8 B stays zero", {gt_out, lt_out, eq_out}, 3'b100);
    a_in = 8'h00; a_ld = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R8 zero equal", {gt_out, lt_out, eq_out}, 3'b001);
    a_ld = 1'b0; b_ld = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R8 reload B", {gt_out, lt_out, eq_out}, 3'b010);

    // R9: asynchronous reset mid-run
    apply(1'b1, 1'b0, 1'b0, 8'h44, 8'h11);
    check("R9 pre", {gt_out, lt_out, eq_out}, 3'b100);
    #2 rst_n = 1'b0;
    #1 check("R9 async", {gt_out, lt_out, eq_out}, 3'b000);
    @(negedge clk); rst_n = 1'b1;
    a_ld = 1'b0; b_ld = 1'b0; res_ld = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9 regs zero", {gt_out, lt_out, eq_out}, 3'b001);

    // R10: chain
    chain(1'b1, 16'h1234, 16'h1234);
    chain(1'b1, 16'h1234, 16'h1235);
    chain(1'b1, 16'h12FF, 16'h1300);
    chain(1'b1, 16'h8000, 16'h7FFF);
    chain(1'b0, 16'h8000, 16'h7FFF);
    chain(1'b0, 16'hFFFF, 16'h0000);
    chain(1'b0, 16'h00FF, 16'h0100);
    chain(1'b0, 16'hFF80, 16'hFF7F);
    xa = 16'h1D3B; xb = 16'hA5C6;
    for (int k = 0; k < 12; k++) begin
      xa = xa * 16'd25173 + 16'd13849;
      xb = (k % 3 == 0) ? {xb[15:8], xa[7:0]} : xb * 16'd3 + 16'd7;
      chain(k[0], xa, xb);
    end

    finish_run();
  end
endmodule